// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDR SDRAM array from power-on to a usable state. It holds the command bus idle after reset. A one-cycle `start` pulse, seen while idle, latches which rows hold memory and then runs a fixed script of commands with fixed gaps between them:

1. A settling interval.
2. A NOP, then a second long interval.
3. A precharge of all banks.
4. Eight auto-refresh (CBR) cycles.
5. A mode-register load with a fixed address pattern.
6. One normal-mode cycle.

After that the block raises its refresh enable and its completion flag in the same cycle and keeps them both high until reset.

Each command goes out on the shared RAS/CAS/WE/address/bank lines. It is addressed only to the rows whose bit was set in the mask captured at start. During every waiting cycle the populated rows see a NOP with their chip selects asserted. A 3-bit mode code output reports which command mode is active, so downstream controller logic can follow the sequence. Every wait length is a parameter given in clock cycles. The defaults suit a 133 MHz clock: 200 µs is 26600 cycles.

The block has no streaming data path. All pins are plain control and status signals that are sampled or driven every cycle, and none of them uses a handshake or back-pressure.

Top module: `sdram_init_top`

## Requirements
- R1: While reset is held, and after reset until a start is taken, `cs_n` is all ones, `ras_n`/`cas_n`/`we_n` are 1, `addr` and `ba` are 0, `mode_code` is 0, and `busy`, `done` and `refresh_en` are 0.
- R2: A `start` high at a clock edge while idle begins the sequence. The first T_STAB cycles after that edge drive NOP (RAS=CAS=WE=1, addr 0).
- R3: A NOP command cycle follows the settling interval, then T_PWR further NOP cycles.
- R4: Precharge-all is driven next for one cycle as RAS=0, CAS=1, WE=0 with address bit AP_BIT (default 10) high and all other address bits 0. It is followed by T_RP NOP cycles.
- R5: Exactly NUM_CBR (default 8) auto-refresh cycles follow, each driven as RAS=0, CAS=0, WE=1, addr 0, and each followed by T_RC NOP cycles.
- R6: One mode-register load follows, driven as RAS=CAS=WE=0 with `addr` = MRS_VAL (default 0x1D0) and `ba` = MRS_BA (default 0). It is followed by T_MRD NOP cycles.
- R7: One normal-mode cycle follows with all chip selects deasserted. In the next cycle `refresh_en` and `done` rise together.
- R8: From the start edge until the normal-mode cycle, `cs_n[r]` is 0 exactly for the rows set in the `row_pop` mask sampled with `start`. Later changes of `row_pop` have no effect. In the normal-mode cycle and afterwards, all `cs_n` bits are 1.
- R9: `busy` is 1 from the cycle after the start edge through the normal-mode cycle. `done` stays 1 until reset. A `start` while busy or after done is ignored.
- R10: `mode_code` reads 0 when idle (refresh off), 1 in NOP and wait cycles, 2 for precharge, 3 for mode-register load, 6 for auto-refresh, and 7 from the normal-mode cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the sequence when idle |
| row_pop | input | NROWS | Populated-row mask, sampled with start |
| cs_n | output | NROWS | Active-low chip select per row |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | AW | Address lines |
| ba | output | BW | Bank address lines |
| mode_code | output | 3 | Current command mode code |
| refresh_en | output | 1 | Periodic refresh enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Initialization complete, sticky |

## Verification
The embedded assertions watch four properties on every cycle:
- no chip select is ever asserted for a row missing from the captured mask;
- the mask holds steady once the sequence has started;
- busy and done never overlap, and done never falls;
- completion only follows a normal-mode cycle, the mode-register load always carries its fixed pattern, and the refresh counter never passes its limit.

Only the bench's scenarios can show the exact command order and the exact length of every gap. For that, the bench compares each cycle against a trace computed from the wait parameters. The same scenarios show that late mask changes and extra start pulses leave the outputs unchanged, including when the mask is empty or full.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    MC_SELF = 3'd0,
    MC_NOP  = 3'd1,
    MC_PRE  = 3'd2,
    MC_MRS  = 3'd3,
    MC_CBR  = 3'd6,
    MC_NORM = 3'd7
  } mode_code_e;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0,
    S_STAB = 4'd1,
    S_NOP  = 4'd2,
    S_WNOP = 4'd3,
    S_PRE  = 4'd4,
    S_WRP  = 4'd5,
    S_CBR  = 4'd6,
    S_WRC  = 4'd7,
    S_MRS  = 4'd8,
    S_WMRD = 4'd9,
    S_NORM = 4'd10,
    S_DONE = 4'd11
  } step_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - TW'(1);
    end
  end

  assign zero = (cnt == '0);

  AST_TMR_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);  // R2

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int NROWS   = 4,
  parameter int T_STAB  = 26600,
  parameter int T_PWR   = 26600,
  parameter int T_RP    = 3,
  parameter int T_RC    = 9,
  parameter int T_MRD   = 2,
  parameter int NUM_CBR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NROWS-1:0] row_pop,
  output step_e            step,
  output logic [NROWS-1:0] pop_q,
  output logic             busy,
  output logic             done,
  output logic             refresh_en
);

  localparam int TMAX = max2(max2(max2(T_STAB, T_PWR), max2(T_RP, T_RC)), T_MRD);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int CW   = $clog2(NUM_CBR + 1);

  logic          t_load;
  logic [TW-1:0] t_val;
  logic          t_zero;
  logic [CW-1:0] cbr_cnt;

  sdram_init_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    case (step)
      S_IDLE: if (start) begin t_load = 1'b1; t_val = TW'(T_STAB - 1); end
      S_NOP:  begin t_load = 1'b1; t_val = TW'(T_PWR - 1); end
      S_PRE:  begin t_load = 1'b1; t_val = TW'(T_RP - 1);  end
      S_CBR:  begin t_load = 1'b1; t_val = TW'(T_RC - 1);  end
      S_MRS:  begin t_load = 1'b1; t_val = TW'(T_MRD - 1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step       <= S_IDLE;
      pop_q      <= '0;
      cbr_cnt    <= '0;
      refresh_en <= 1'b0;
    end else begin
      case (step)
        S_IDLE: if (start) begin
          step    <= S_STAB;
          pop_q   <= row_pop;
          cbr_cnt <= '0;
        end
        S_STAB: if (t_zero) step <= S_NOP;
        S_NOP:  step <= S_WNOP;
        S_WNOP: if (t_zero) step <= S_PRE;
        S_PRE:  step <= S_WRP;
        S_WRP:  if (t_zero) step <= S_CBR;
        S_CBR: begin
          step    <= S_WRC;
          cbr_cnt <= cbr_cnt + CW'(1);
        end
        S_WRC:  if (t_zero) step <= (cbr_cnt == CW'(NUM_CBR)) ? S_MRS : S_CBR;
        S_MRS:  step <= S_WMRD;
        S_WMRD: if (t_zero) step <= S_NORM;
        S_NORM: begin
          step       <= S_DONE;
          refresh_en <= 1'b1;
        end
        S_DONE: ;
        default: step <= S_IDLE;
      endcase
    end
  end

  assign busy = (step != S_IDLE) && (step != S_DONE);
  assign done = (step == S_DONE);

  AST_CBR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_cnt <= CW'(NUM_CBR));  // R5

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (step != S_IDLE) |=> $stable(pop_q));  // R8

endmodule

// File: rtl/sdram_init_enc.sv
module sdram_init_enc
  import sdram_init_pkg::*;
#(
  parameter int NROWS   = 4,
  parameter int AW      = 13,
  parameter int BW      = 2,
  parameter int AP_BIT  = 10,
  parameter int MRS_VAL = 'h1D0,
  parameter int MRS_BA  = 0
) (
  input  step_e            step,
  input  logic [NROWS-1:0] pop_q,
  output logic [NROWS-1:0] cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [AW-1:0]    addr,
  output logic [BW-1:0]    ba,
  output mode_code_e       mode
);

  logic sel;

  always_comb begin
    mode  = MC_SELF;
    sel   = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    addr  = '0;
    ba    = '0;
    case (step)
      S_STAB, S_NOP, S_WNOP, S_WRP, S_WRC, S_WMRD: begin
        mode = MC_NOP;
        sel  = 1'b1;
      end
      S_PRE: begin
        mode         = MC_PRE;
        sel          = 1'b1;
        ras_n        = 1'b0;
        we_n         = 1'b0;
        addr[AP_BIT] = 1'b1;
      end
      S_CBR: begin
        mode  = MC_CBR;
        sel   = 1'b1;
        ras_n = 1'b0;
        cas_n = 1'b0;
      end
      S_MRS: begin
        mode  = MC_MRS;
        sel   = 1'b1;
        ras_n = 1'b0;
        cas_n = 1'b0;
        we_n  = 1'b0;
        addr  = AW'(MRS_VAL);
        ba    = BW'(MRS_BA);
      end
      S_NORM, S_DONE: mode = MC_NORM;
      default: ;
    endcase
  end

  for (genvar g = 0; g < NROWS; g++) begin : g_row
    assign cs_n[g] = ~(sel & pop_q[g]);
  end

endmodule

// File: rtl/sdram_init_top.sv
module sdram_init_top
  import sdram_init_pkg::*;
#(
  parameter int NROWS   = 4,
  parameter int AW      = 13,
  parameter int BW      = 2,
  parameter int T_STAB  = 26600,
  parameter int T_PWR   = 26600,
  parameter int T_RP    = 3,
  parameter int T_RC    = 9,
  parameter int T_MRD   = 2,
  parameter int NUM_CBR = 8,
  parameter int AP_BIT  = 10,
  parameter int MRS_VAL = 'h1D0,
  parameter int MRS_BA  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NROWS-1:0] row_pop,
  output logic [NROWS-1:0] cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [AW-1:0]    addr,
  output logic [BW-1:0]    ba,
  output logic [2:0]       mode_code,
  output logic             refresh_en,
  output logic             busy,
  output logic             done
);

  step_e            step;
  logic [NROWS-1:0] pop_q;
  mode_code_e       mode;

  sdram_init_seq #(
    .NROWS(NROWS), .T_STAB(T_STAB), .T_PWR(T_PWR), .T_RP(T_RP),
    .T_RC(T_RC), .T_MRD(T_MRD), .NUM_CBR(NUM_CBR)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .row_pop    (row_pop),
    .step       (step),
    .pop_q      (pop_q),
    .busy       (busy),
    .done       (done),
    .refresh_en (refresh_en)
  );

  sdram_init_enc #(
    .NROWS(NROWS), .AW(AW), .BW(BW), .AP_BIT(AP_BIT),
    .MRS_VAL(MRS_VAL), .MRS_BA(MRS_BA)
  ) u_enc (
    .step  (step),
    .pop_q (pop_q),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .addr  (addr),
    .ba    (ba),
    .mode  (mode)
  );

  assign mode_code = mode;

  AST_CS_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cs_n) & (~pop_q)) == '0);  // R8

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));  // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);  // R9

  AST_DONE_AFTER_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(mode_code) == 3'd7 && refresh_en));  // R7

  AST_MRS_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd3) |-> (addr == AW'(MRS_VAL) && !ras_n && !cas_n && !we_n));  // R6

endmodule

// File: tb/sdram_init_top_tb.sv
module sdram_init_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 4;
  localparam int AW    = 13;
  localparam int BW    = 2;
  localparam int TS    = 12;
  localparam int TP    = 10;
  localparam int TRP   = 3;
  localparam int TRC   = 4;
  localparam int TMRD  = 2;
  localparam int NCBR  = 8;
  localparam int APB   = 10;
  localparam int MRSV  = 'h1D0;
  localparam int TOTAL = TS + 1 + TP + 1 + TRP + NCBR * (1 + TRC) + 1 + TMRD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NROWS-1:0] row_pop = '0;
  logic [NROWS-1:0] cs_n;
  logic ras_n, cas_n, we_n;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;
  logic [2:0] mode_code;
  logic refresh_en, busy, done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_top #(
    .NROWS(NROWS), .AW(AW), .BW(BW), .T_STAB(TS), .T_PWR(TP), .T_RP(TRP),
    .T_RC(TRC), .T_MRD(TMRD), .NUM_CBR(NCBR), .AP_BIT(APB), .MRS_VAL(MRSV), .MRS_BA(0)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .row_pop(row_pop), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
    .mode_code(mode_code), .refresh_en(refresh_en), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected mode code for cycle index i after the start edge
  function automatic logic [2:0] exp_mode(input int i);
    int p = i;
    if (p < TS) return 3'd1;
    p -= TS;
    if (p == 0) return 3'd1;
    p -= 1;
    if (p < TP) return 3'd1;
    p -= TP;
    if (p == 0) return 3'd2;
    p -= 1;
    if (p < TRP) return 3'd1;
    p -= TRP;
    for (int k = 0; k < NCBR; k++) begin
      if (p == 0) return 3'd6;
      p -= 1;
      if (p < TRC) return 3'd1;
      p -= TRC;
    end
    if (p == 0) return 3'd3;
    p -= 1;
    if (p < TMRD) return 3'd1;
    return 3'd7;
  endfunction

  function automatic string tag_of(input int i, input logic [2:0] m);
    case (m)
      3'd1: return (i < TS) ? "R2" : "R3";
      3'd2: return "R4";
      3'd6: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  // packed bus: {ras,cas,we,addr,ba}
  function automatic logic [31:0] exp_bus(input logic [2:0] m);
    logic [AW-1:0] a;
    a = '0;
    case (m)
      3'd2: begin a[APB] = 1'b1; return {14'd0, 3'b010, a, 2'b00}; end
      3'd6: return {14'd0, 3'b001, a, 2'b00};
      3'd3: return {14'd0, 3'b000, AW'(MRSV), 2'b00};
      default: return {14'd0, 3'b111, a, 2'b00};
    endcase
  endfunction

  function automatic logic [31:0] act_bus();
    return {14'd0, ras_n, cas_n, we_n, addr, ba};
  endfunction

  task automatic check_cycle(input int i, input logic [NROWS-1:0] mask);
    logic [2:0] m;
    logic [NROWS-1:0] ecs;
    m = exp_mode(i);
    ecs = (i < TOTAL) ? ~mask : '1;
    chk(act_bus() == exp_bus(m), tag_of(i, m), act_bus(), exp_bus(m));
    chk(mode_code == m, "R10 mode_code", 32'(mode_code), 32'(m));
    chk(cs_n == ecs, "R8 cs_n", 32'(cs_n), 32'(ecs));
    chk(busy == (i <= TOTAL), "R9 busy", 32'(busy), 32'(i <= TOTAL));
    chk(done == (i > TOTAL), "R9 done", 32'(done), 32'(i > TOTAL));
    chk(refresh_en == (i > TOTAL), "R7 refresh_en", 32'(refresh_en), 32'(i > TOTAL));
  endtask

  task automatic check_idle(input string tag);
    chk(cs_n == '1, tag, 32'(cs_n), 32'hF);
    chk(act_bus() == exp_bus(3'd1), tag, act_bus(), exp_bus(3'd1));
    chk(mode_code == 3'd0, tag, 32'(mode_code), 0);
    chk({busy, done, refresh_en} == 3'b000, tag, 32'({busy, done, refresh_en}), 0);
  endtask

  task automatic run_seq(input logic [NROWS-1:0] mask, input bit disturb);
    rst_n = 1'b0;
    start = 1'b0;
    row_pop = mask;
    repeat (2) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 idle without start");
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i <= TOTAL + 4; i++) begin
      check_cycle(i, mask);
      if (disturb && (i == 20 || i == 40)) begin
        row_pop = ~mask;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    // start after done is ignored
    start = 1'b1;
    row_pop = ~mask;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < 3; j++) begin
      check_cycle(TOTAL + 5 + j, mask);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_seq(4'b0000, 1'b0);
    run_seq(4'b1111, 1'b0);
    run_seq(4'b0101, 1'b1);
    for (int r = 0; r < 3; r++) begin
      run_seq(NROWS'($urandom), r[0]);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule